// File: doc/BRIEF.md
# Terminal Load Retirement Buffer

This block sits next to a small reorder buffer that commits in program order. It gives special handling to one kind of load: a load whose value is used only to be passed on to a consumer. Such a load is flagged at dispatch and carries a sequence ID. If it reaches the oldest slot before its memory data has come back, it is moved into a small side buffer. The head then advances and younger work keeps committing. When the data arrives, the entry is written to an output queue together with its ID. A flagged load whose data is already present at the head goes straight to the queue.

Memory is modelled by a response port that returns a tag and a data word. A response is matched by tag to the entry that carries it, whether that entry is still in the reorder buffer or already in the side buffer. The consumer's queue can signal that it is full, and the block then emits nothing. All other instructions, including ordinary loads, commit strictly in order and use the same commit slots.

Top module: `tl_retire_buf`

## Requirements
- R1: After reset, `disp_ready` is 1, `out_valid` is 0 and `commit_cnt` is 0.
- R2: Instructions commit strictly in order. An ordinary load (`disp_load`=1, `disp_term`=0) at the head whose data has not returned blocks every younger entry. A non-load (`disp_load`=0, `disp_term`=0) is ready at dispatch. A flagged load is treated as a load even if `disp_load` is 0.
- R3: At most `CW` entries commit per cycle, counted in `commit_cnt`, and never more than the reorder buffer holds.
- R4: A flagged load that is not ready at the head moves into the side buffer if the side buffer has room at the start of the cycle. The move counts as a commit, and younger ready entries may commit in the same cycle.
- R5: A flagged load that is ready at the head is written to the queue in its commit cycle, with its ID and data. It never enters the side buffer.
- R6: A side-buffer entry whose data has arrived is emitted with its ID and the returned data. The data is captured whether the response came while the entry was in the reorder buffer or in the side buffer.
- R7: When the side buffer is full at the start of a cycle, a not-ready flagged load at the head stalls commit.
- R8: At most one entry is emitted per cycle. Among ready side-buffer entries, the one that left the head first is emitted first. A side-buffer emission takes priority over a direct write from the head.
- R9: While `q_full` is 1, `out_valid` stays 0, and a ready flagged load at the head stalls commit.
- R10: At most one flagged load is handled at the head per cycle, whether it is moved or written directly. Commit stops at a second flagged load in the same cycle.
- R11: `disp_ready` is 0 while the reorder buffer holds `ROB_DEPTH` entries.
- R12: In a mix of long-latency (6 cycles) and short-latency (2 cycles) flagged loads, every ID is delivered exactly once with correct data. A short load that is younger than a long load is delivered before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch an instruction into the reorder buffer |
| disp_load | input | 1 | Instruction is a load |
| disp_term | input | 1 | Load is flagged as forward-only |
| disp_tag | input | TAG_W | Memory tag of the load |
| disp_id | input | ID_W | Sequence ID sent with the forwarded value |
| disp_ready | output | 1 | Reorder buffer can accept a dispatch |
| rsp_valid | input | 1 | Memory response valid |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_data | input | DATA_W | Returned data |
| commit_cnt | output | $clog2(CW+1) | Number of entries committed this cycle |
| q_full | input | 1 | Output queue cannot take an entry |
| out_valid | output | 1 | Queue write this cycle |
| out_id | output | ID_W | Sequence ID of the written entry |
| out_data | output | DATA_W | Data of the written entry |

## Verification
The bench targets the cases where the side buffer is full, and where the queue is blocked so that two ready side-buffer entries wait together. A design that got the full case wrong would overwrite a live entry. One that got the blocked case wrong would emit the younger ID first. It also places two flagged loads back to back at the head. There, a design without the one-per-cycle limit would either drop one of them or handle both in a single cycle. Finally, it runs the interleaved 6-cycle and 2-cycle pattern. A design that still blocked on the long load would deliver the short IDs late. One that lost track of tags would emit wrong data or repeat an ID.

// File: rtl/tl_retire_buf.sv
`timescale 1ns/1ps
module tl_retire_buf #(
  parameter int CW        = 2,
  parameter int ROB_DEPTH = 4,
  parameter int SB_DEPTH  = 2,
  parameter int TAG_W     = 4,
  parameter int ID_W      = 8,
  parameter int DATA_W    = 16,
  localparam int PW   = $clog2(ROB_DEPTH),
  localparam int CNTW = $clog2(ROB_DEPTH + 1),
  localparam int CCW  = $clog2(CW + 1),
  localparam int SBW  = $clog2(SB_DEPTH + 1),
  localparam int SIW  = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic              disp_load,
  input  logic              disp_term,
  input  logic [TAG_W-1:0]  disp_tag,
  input  logic [ID_W-1:0]   disp_id,
  output logic              disp_ready,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [CCW-1:0]    commit_cnt,
  input  logic              q_full,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] out_data
);
  logic [ROB_DEPTH-1:0] r_ld, r_tm, r_rdy;
  logic [TAG_W-1:0]     r_tag [ROB_DEPTH];
  logic [ID_W-1:0]      r_id  [ROB_DEPTH];
  logic [DATA_W-1:0]    r_dat [ROB_DEPTH];
  logic [PW-1:0]        head, tail, tix;
  logic [CNTW-1:0]      cnt;

  logic [SB_DEPTH-1:0]  s_rdy, u_rdy, n_rdy;
  logic [TAG_W-1:0]     s_tag [SB_DEPTH], n_tag [SB_DEPTH];
  logic [ID_W-1:0]      s_id  [SB_DEPTH], n_id  [SB_DEPTH];
  logic [DATA_W-1:0]    s_dat [SB_DEPTH], u_dat [SB_DEPTH], n_dat [SB_DEPTH];
  logic [SBW-1:0]       scnt;
  logic [SIW-1:0]       dsel;

  logic push, mv, dir, drain;
  logic [CCW-1:0] ncom;

  assign disp_ready = cnt != CNTW'(ROB_DEPTH);
  assign push       = disp_valid && disp_ready;
  assign commit_cnt = ncom;
  assign out_valid  = drain | dir;
  assign out_id     = drain ? s_id[dsel]  : r_id[tix];
  assign out_data   = drain ? s_dat[dsel] : r_dat[tix];

  always_comb begin
    drain = 1'b0;
    dsel  = '0;
    for (int k = SB_DEPTH - 1; k >= 0; k--)
      if (!q_full && s_rdy[k] && SBW'(k) < scnt) begin
        drain = 1'b1;
        dsel  = SIW'(k);
      end
  end

  always_comb begin
    logic stop;
    logic [PW-1:0] ix;
    ncom = '0;
    stop = 1'b0;
    mv   = 1'b0;
    dir  = 1'b0;
    tix  = head;
    for (int i = 0; i < CW; i++) begin
      ix = head + PW'(i);
      if (!stop && CNTW'(i) < cnt) begin
        if (r_tm[ix]) begin
          if (mv || dir) stop = 1'b1;
          else if (r_rdy[ix] && !q_full && !drain) begin
            dir = 1'b1; tix = ix; ncom = ncom + CCW'(1);
          end else if (!r_rdy[ix] && scnt != SBW'(SB_DEPTH)) begin
            mv = 1'b1; tix = ix; ncom = ncom + CCW'(1);
          end else stop = 1'b1;
        end else if (r_rdy[ix]) ncom = ncom + CCW'(1);
        else stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; cnt <= '0;
      r_ld <= '0; r_tm <= '0; r_rdy <= '0;
    end else begin
      for (int j = 0; j < ROB_DEPTH; j++)
        if (rsp_valid && r_ld[j] && !r_rdy[j] && r_tag[j] == rsp_tag) begin
          r_rdy[j] <= 1'b1;
          r_dat[j] <= rsp_data;
        end
      if (push) begin
        r_ld[tail]  <= disp_load | disp_term;
        r_tm[tail]  <= disp_term;
        r_rdy[tail] <= !(disp_load | disp_term);
        r_tag[tail] <= disp_tag;
        r_id[tail]  <= disp_id;
        tail        <= tail + PW'(1);
      end
      head <= head + PW'(ncom);
      cnt  <= cnt + CNTW'(push) - CNTW'(ncom);
    end
  end

  always_comb begin
    logic [SIW-1:0] pos;
    for (int k = 0; k < SB_DEPTH; k++) begin
      u_rdy[k] = s_rdy[k] | (rsp_valid && s_tag[k] == rsp_tag);
      u_dat[k] = (rsp_valid && !s_rdy[k] && s_tag[k] == rsp_tag) ? rsp_data : s_dat[k];
    end
    n_rdy = u_rdy;
    n_tag = s_tag;
    n_id  = s_id;
    n_dat = u_dat;
    for (int k = 0; k < SB_DEPTH - 1; k++)
      if (drain && SIW'(k) >= dsel) begin
        n_rdy[k] = u_rdy[k+1];
        n_tag[k] = s_tag[k+1];
        n_id[k]  = s_id[k+1];
        n_dat[k] = u_dat[k+1];
      end
    pos = SIW'(scnt - SBW'(drain));
    if (mv) begin
      n_rdy[pos] = rsp_valid && rsp_tag == r_tag[tix];
      n_tag[pos] = r_tag[tix];
      n_id[pos]  = r_id[tix];
      n_dat[pos] = (r_rdy[tix]) ? r_dat[tix] : rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_rdy <= '0;
      scnt  <= '0;
    end else begin
      s_rdy <= n_rdy;
      s_tag <= n_tag;
      s_id  <= n_id;
      s_dat <= n_dat;
      scnt  <= scnt + SBW'(mv) - SBW'(drain);
    end
  end
endmodule

// File: rtl/tl_retire_buf_chk.sv
`timescale 1ns/1ps
module tl_retire_buf_chk #(
  parameter int CW = 2, parameter int ROB_DEPTH = 4, parameter int SB_DEPTH = 2,
  parameter int CNTW = 3, parameter int SBW = 2, parameter int CCW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            q_full,
  input logic            out_valid,
  input logic            disp_ready,
  input logic            mv,
  input logic            dir,
  input logic            drain,
  input logic [CCW-1:0]  commit_cnt,
  input logic [CNTW-1:0] cnt,
  input logic [SBW-1:0]  scnt
);
  assert_no_emit_when_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !q_full);
  assert_sb_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scnt) <= SB_DEPTH);
  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scnt) == SB_DEPTH |-> !mv);
  assert_commit_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(commit_cnt) <= CW && int'(commit_cnt) <= int'(cnt));
  assert_one_terminal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv && dir));
  assert_rob_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == ROB_DEPTH |-> !disp_ready);
  assert_sb_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(scnt) == int'($past(scnt)) + int'($past(mv)) - int'($past(drain)));
endmodule

bind tl_retire_buf tl_retire_buf_chk #(
  .CW(CW), .ROB_DEPTH(ROB_DEPTH), .SB_DEPTH(SB_DEPTH),
  .CNTW(CNTW), .SBW(SBW), .CCW(CCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .q_full(q_full), .out_valid(out_valid),
  .disp_ready(disp_ready), .mv(mv), .dir(dir), .drain(drain),
  .commit_cnt(commit_cnt), .cnt(cnt), .scnt(scnt)
);

// File: tb/sim_tl_retire_buf.sv
`timescale 1ns/1ps
module sim_tl_retire_buf;
  localparam int TAG_W = 4, ID_W = 8, DATA_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_load = 0, disp_term = 0, disp_ready;
  logic [TAG_W-1:0] disp_tag = '0, rsp_tag = '0;
  logic [ID_W-1:0] disp_id = '0, out_id;
  logic rsp_valid = 0, q_full = 0, out_valid;
  logic [DATA_W-1:0] rsp_data = '0, out_data;
  logic [1:0] commit_cnt;

  tl_retire_buf u0 (.clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_load(disp_load),
    .disp_term(disp_term), .disp_tag(disp_tag), .disp_id(disp_id), .disp_ready(disp_ready),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data), .commit_cnt(commit_cnt),
    .q_full(q_full), .out_valid(out_valid), .out_id(out_id), .out_data(out_data));

  always #5 clk = ~clk;

  int nt = 0, nf = 0, cycles = 0;
  bit qf = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nt++; nf++;
      $display("FAIL watchdog all actual=%0d expected=<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] dat(int t);
    return 16'hA000 + 16'(t * 17);
  endfunction

  task automatic ck(string r, int act, int exp);
    nt++;
    if (act != exp) begin
      nf++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic go(bit dv, bit ld, bit tm, int tag, int id, bit rv, int rt);
    @(negedge clk);
    q_full = qf;
    disp_valid = dv; disp_load = ld; disp_term = tm;
    disp_tag = TAG_W'(tag); disp_id = ID_W'(id);
    rsp_valid = rv; rsp_tag = TAG_W'(rt); rsp_data = dat(rt);
    #1;
  endtask

  task automatic dL(int tag);         go(1, 1, 0, tag, 0, 0, 0); endtask
  task automatic dT(int tag, int id); go(1, 1, 1, tag, id, 0, 0); endtask
  task automatic dN();                go(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic rs(int tag);         go(0, 0, 0, 0, 0, 1, tag); endtask
  task automatic idle();              go(0, 0, 0, 0, 0, 0, 0); endtask

  int due [16];
  bit pend [16];
  int seen [8];
  int nout, ndisp, ncommit, best;

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    ck("R1 disp_ready", int'(disp_ready), 1);
    ck("R1 out_valid", int'(out_valid), 0);
    ck("R1 commit_cnt", int'(commit_cnt), 0);

    // R2 / R3: ordinary load blocks younger work, then CW-wide commit
    dL(1);  ck("R2 empty", int'(commit_cnt), 0);
    dN();   ck("R2 blocked", int'(commit_cnt), 0);
    dN();   ck("R2 blocked", int'(commit_cnt), 0);
    rs(1);  ck("R2 blocked", int'(commit_cnt), 0);
    idle(); ck("R3 width", int'(commit_cnt), 2);
    idle(); ck("R3 rest", int'(commit_cnt), 1);
    idle(); ck("R2 drained", int'(commit_cnt), 0);

    // R4 / R6: not-ready flagged load moves aside
    dL(3); dT(4, 9); dN(); rs(3);
    idle(); ck("R4 move commit", int'(commit_cnt), 2); ck("R4 no emit", int'(out_valid), 0);
    idle(); ck("R4 younger", int'(commit_cnt), 1);
    rs(4);  ck("R6 before data", int'(out_valid), 0);
    idle(); ck("R6 emit", int'(out_valid), 1); ck("R6 id", int'(out_id), 9);
            ck("R6 data", int'(out_data), int'(dat(4)));
    idle(); ck("R6 once", int'(out_valid), 0);

    // R5: ready flagged load written directly
    dL(5); dT(6, 11); rs(6); rs(5);
    idle(); ck("R5 commit", int'(commit_cnt), 2); ck("R5 emit", int'(out_valid), 1);
            ck("R5 id", int'(out_id), 11); ck("R5 data", int'(out_data), int'(dat(6)));
    idle(); ck("R5 not buffered", int'(out_valid), 0);

    // R9 / R10: blocked queue, then two flagged loads at the head
    qf = 1;
    dL(7); dT(8, 30); dT(9, 31); rs(8); rs(7);
    idle(); ck("R9 stall", int'(commit_cnt), 1); ck("R9 no emit", int'(out_valid), 0);
    qf = 0;
    idle(); ck("R10 one terminal", int'(commit_cnt), 1); ck("R10 id", int'(out_id), 30);
    idle(); ck("R10 next moves", int'(commit_cnt), 1); ck("R10 no emit", int'(out_valid), 0);
    rs(9);
    idle(); ck("R6 id31", int'(out_id), 31);
    idle();

    // R7 / R8: full side buffer, ordered drain
    qf = 1;
    dT(10, 20);
    dT(11, 21); ck("R4 move a", int'(commit_cnt), 1);
    dT(12, 22); ck("R4 move b", int'(commit_cnt), 1);
    dN();       ck("R7 full stall", int'(commit_cnt), 0);
    rs(11);     ck("R7 full stall", int'(commit_cnt), 0);
    rs(10);     ck("R9 blocked", int'(out_valid), 0);
    idle();     ck("R9 blocked", int'(out_valid), 0);
    qf = 0;
    idle(); ck("R8 older first", int'(out_id), 20); ck("R7 still full", int'(commit_cnt), 0);
    idle(); ck("R8 second", int'(out_id), 21); ck("R7 freed", int'(commit_cnt), 2);
    rs(12); ck("R8 one per cycle", int'(out_valid), 0);
    idle(); ck("R6 id22", int'(out_id), 22); ck("R6 data22", int'(out_data), int'(dat(12)));
    idle();

    // R11: full reorder buffer
    dL(13); dN(); dN(); dN();
    idle(); ck("R11 full", int'(disp_ready), 0);
    rs(13); idle(); idle(); idle();
    ck("R11 free", int'(disp_ready), 1);

    // R12: 6-cycle loads ahead of 2-cycle loads
    for (int t = 0; t < 16; t++) pend[t] = 0;
    for (int t = 0; t < 8; t++) seen[t] = -1;
    nout = 0; ndisp = 0; ncommit = 0;
    for (int c = 0; c < 300 && nout < 8; c++) begin
      @(negedge clk);
      q_full = 0; disp_valid = 0; rsp_valid = 0;
      if (ndisp < 8 && disp_ready) begin
        disp_valid = 1; disp_load = 1; disp_term = 1;
        disp_tag = TAG_W'(ndisp); disp_id = ID_W'(ndisp);
        due[ndisp] = c + ((ndisp % 2 == 0) ? 6 : 2);
        pend[ndisp] = 1;
        ndisp++;
      end
      best = -1;
      for (int t = 0; t < 16; t++)
        if (pend[t] && due[t] <= c && (best < 0 || due[t] < due[best])) best = t;
      if (best >= 0) begin
        rsp_valid = 1; rsp_tag = TAG_W'(best); rsp_data = dat(best); pend[best] = 0;
      end
      #1;
      ncommit += int'(commit_cnt);
      if (out_valid) begin
        if (out_id < 8) begin
          ck("R12 dup", seen[out_id], -1);
          seen[out_id] = nout;
        end
        ck("R12 data", int'(out_data), int'(dat(int'(out_id))));
        nout++;
      end
    end
    ck("R12 delivered", nout, 8);
    ck("R12 short first", int'(seen[1] < seen[0]), 1);
    ck("R4 all commit", ncommit, 8);

    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule